// File: doc/BRIEF.md
# Two-Level Nanocoded Control Sequencer

The block is the control unit of a microprogrammed processor, built with two levels of stored control. A micro-program counter selects a 17-bit microword from a small microcode store. A microword is one of two kinds. A jump word steers the micro-program counter. A nano word carries a pointer into a shared nanostore, whose entries are 68 bits wide. The selected nanoword is expanded by pure combinational logic into 196 individual datapath control strobes. A control pattern that many microroutines use is therefore kept only once, in the nanostore, and the microcode stays narrow.

A macro-opcode input chooses the microroutine that a dispatch jump enters. A condition-flag input decides conditional micro-branches. Both stores are constant tables computed at elaboration. The control vector is a combinational function of the current micro-program counter, so it is valid during the same cycle that the microword is executing.

Top module: `nano_sequencer`

## Requirements
- R1: While reset is high, and in the first cycle after it is released, the micro-program counter is 0. Address 0 holds the first word of the fetch routine, so the output then shows the expansion of nanoword 1.
- R2: Bit 16 of a microword selects its kind: 0 means a nano word. For a nano word, bits 8:0 are the nanostore pointer and the next micro-program counter is the current value + 1, wrapping modulo 128.
- R3: For a jump word (bit 16 = 1), bits 15:14 hold the condition code and bits 9:0 hold the target. The target modulo 128 is the next address. Code 00 jumps unconditionally.
- R4: Code 01 jumps only when the condition flag is 1, and code 10 jumps only when the flag is 0. When the jump is not taken, the next address is the current one + 1.
- R5: Code 11 dispatches on the 4-bit macro-opcode. The next address is 4 + 4*opcode.
- R6: While a jump word executes, all 196 control outputs are 0.
- R7: When a nano word executes, nanoword bits [4i+3:4i] (i = 0..8) select one line of output group [16i+15:16i]. Nanoword bits [36+3j+2:36+3j] (j = 0..3) select one line of output group [144+8j+7:144+8j]. Each group then has exactly one active line, at the index given by its code.
- R8: Nanoword bits 67:48 drive outputs 195:176 directly, in the same bit order.
- R9: Microprogram layout. Address 0 is nano 1. Address 1 is nano 2. Address 2 is a dispatch. Address 3 is an unconditional jump to 0. For opcode k, with base b = 4+4k, the routine is: b = nano k+3; b+1 = jump to 0, on code 01 for even k and on code 10 for odd k; b+2 = nano k+20; b+3 = unconditional jump to 0. Addresses 68..127 are unconditional jumps to 0.
- R10: Nanostore content. In nanoword p (0..63), bits [4n+3:4n] hold (p + 3n) mod 16, for n = 0..16.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| op_code | input | 4 | Macro-opcode used by dispatch jumps |
| cond_flag | input | 1 | Condition flag tested by conditional jumps |
| ctrl_out | output | 196 | Expanded datapath control strobes |

## Verification
Every cycle, the assertions check how the micro-program counter moves for each microword kind and condition code: fall-through, taken and untaken jumps, dispatch, and reset to zero. They also check that a jump word forces the strobes to zero and that each decoded group is one-hot during a nano word. Only the bench scenarios can show that the stored contents are right, meaning the layout of the microroutines, the nanoword values and the mapping of bits to strobes. The bench shows this by comparing the whole 196-bit vector against a model written from the requirements. It does so while walking every opcode routine with both flag values and a long random mix of opcodes and flags.

// File: rtl/nseq_pkg.sv
package nseq_pkg;
    localparam int UW         = 17;
    localparam int JAW        = 10;
    localparam int NPW        = 9;
    localparam int OPW        = 4;
    localparam int UDEPTH     = 128;
    localparam int NDEPTH     = 64;
    localparam int UAW        = $clog2(UDEPTH);
    localparam int NAW        = $clog2(NDEPTH);
    localparam int N_WIDE     = 9;
    localparam int WIDE_W     = 4;
    localparam int N_NARROW   = 4;
    localparam int NARROW_W   = 3;
    localparam int N_DIRECT   = 20;
    localparam int WIDE_BITS  = N_WIDE * WIDE_W;
    localparam int NARROW_BITS= N_NARROW * NARROW_W;
    localparam int NW         = WIDE_BITS + NARROW_BITS + N_DIRECT;
    localparam int WIDE_LINES = 1 << WIDE_W;
    localparam int NARROW_LINES = 1 << NARROW_W;
    localparam int WIDE_OUT   = N_WIDE * WIDE_LINES;
    localparam int NARROW_OUT = N_NARROW * NARROW_LINES;
    localparam int CW         = WIDE_OUT + NARROW_OUT + N_DIRECT;
    localparam int DISP_BASE  = 4;
    localparam int ROUT_SH    = 2;
    localparam int N_OPS      = 1 << OPW;
    localparam int ROUT_END   = DISP_BASE + (N_OPS << ROUT_SH);

    typedef enum logic [1:0] {
        C_ALWAYS = 2'b00,
        C_SET    = 2'b01,
        C_CLR    = 2'b10,
        C_DISP   = 2'b11
    } cond_e;

    typedef struct packed {
        logic           jump;
        cond_e          cond;
        logic [UAW-1:0] tgt;
        logic [NAW-1:0] ptr;
    } uop_t;

    typedef struct packed {
        logic [UAW-1:0] upc;
    } seq_t;

    function automatic logic [UW-1:0] mk_jump(cond_e c, int t);
        return {1'b1, c, {(UW-3-JAW){1'b0}}, JAW'(t)};
    endfunction

    function automatic logic [UW-1:0] mk_nano(int p);
        return {1'b0, {(UW-1-NPW){1'b0}}, NPW'(p)};
    endfunction

    function automatic logic [UW-1:0] ucode_word(int a);
        int k;
        int s;
        if (a == 0)              return mk_nano(1);
        else if (a == 1)         return mk_nano(2);
        else if (a == 2)         return mk_jump(C_DISP, 0);
        else if (a < DISP_BASE || a >= ROUT_END) return mk_jump(C_ALWAYS, 0);
        k = (a - DISP_BASE) >> ROUT_SH;
        s = (a - DISP_BASE) % (1 << ROUT_SH);
        case (s)
            0:       return mk_nano(k + 3);
            1:       return mk_jump((k % 2 == 1) ? C_CLR : C_SET, 0);
            2:       return mk_nano(k + 20);
            default: return mk_jump(C_ALWAYS, 0);
        endcase
    endfunction

    function automatic logic [NW-1:0] nano_word(int p);
        logic [NW-1:0] w;
        w = '0;
        for (int n = 0; n < NW / 4; n++) begin
            w[4*n +: 4] = 4'((p + 3 * n) % 16);
        end
        return w;
    endfunction
endpackage

// File: rtl/nseq_ustore.sv
module nseq_ustore
    import nseq_pkg::*;
(
    input  logic [UAW-1:0] addr,
    output uop_t           uop
);
    uop_t rom [UDEPTH];

    for (genvar i = 0; i < UDEPTH; i++) begin : g_rom
        localparam logic [UW-1:0] W = ucode_word(i);
        assign rom[i] = '{jump: W[UW-1],
                          cond: cond_e'(W[UW-2 -: 2]),
                          tgt:  W[UAW-1:0],
                          ptr:  W[NAW-1:0]};
    end

    assign uop = rom[addr];
endmodule

// File: rtl/nseq_nstore.sv
module nseq_nstore
    import nseq_pkg::*;
(
    input  logic [NAW-1:0] ptr,
    output logic [NW-1:0]  nword
);
    logic [NW-1:0] rom [NDEPTH];

    for (genvar i = 0; i < NDEPTH; i++) begin : g_rom
        assign rom[i] = nano_word(i);
    end

    assign nword = rom[ptr];
endmodule

// File: rtl/nseq_expand.sv
module nseq_expand
    import nseq_pkg::*;
(
    input  logic [NW-1:0] nword,
    output logic [CW-1:0] strobes
);
    for (genvar i = 0; i < N_WIDE; i++) begin : g_wide
        logic [WIDE_W-1:0] code;
        assign code = nword[i*WIDE_W +: WIDE_W];
        assign strobes[i*WIDE_LINES +: WIDE_LINES] = WIDE_LINES'(1) << code;
    end

    for (genvar j = 0; j < N_NARROW; j++) begin : g_narrow
        logic [NARROW_W-1:0] code;
        assign code = nword[WIDE_BITS + j*NARROW_W +: NARROW_W];
        assign strobes[WIDE_OUT + j*NARROW_LINES +: NARROW_LINES] =
            NARROW_LINES'(1) << code;
    end

    assign strobes[WIDE_OUT + NARROW_OUT +: N_DIRECT] =
        nword[WIDE_BITS + NARROW_BITS +: N_DIRECT];
endmodule

// File: rtl/nano_sequencer.sv
module nano_sequencer
    import nseq_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic [OPW-1:0] op_code,
    input  logic           cond_flag,
    output logic [CW-1:0]  ctrl_out
);
    seq_t           state_d, state_q;
    uop_t           uop;
    logic [NW-1:0]  nword;
    logic [CW-1:0]  strobes;
    logic [UAW-1:0] upc_cur;
    logic [UAW-1:0] upc_inc;
    logic [UAW-1:0] disp_tgt;

    assign upc_cur  = state_q.upc;
    assign upc_inc  = upc_cur + UAW'(1);
    assign disp_tgt = UAW'(DISP_BASE) + (UAW'(op_code) << ROUT_SH);

    nseq_ustore u_ustore (.addr(upc_cur), .uop(uop));
    nseq_nstore u_nstore (.ptr(uop.ptr), .nword(nword));
    nseq_expand u_expand (.nword(nword), .strobes(strobes));

    always_comb begin
        state_d = state_q;
        if (!uop.jump) begin
            state_d.upc = upc_inc;
        end else begin
            unique case (uop.cond)
                C_ALWAYS: state_d.upc = uop.tgt;
                C_SET:    state_d.upc = cond_flag  ? uop.tgt : upc_inc;
                C_CLR:    state_d.upc = !cond_flag ? uop.tgt : upc_inc;
                C_DISP:   state_d.upc = disp_tgt;
                default:  state_d.upc = upc_inc;
            endcase
        end
        ctrl_out = uop.jump ? '0 : strobes;
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= '{upc: '0};
        else     state_q <= state_d;
    end
endmodule

// File: rtl/nano_sequencer_chk.sv
module nano_sequencer_chk
    import nseq_pkg::*;
(
    input logic           clk,
    input logic           rst,
    input logic [UAW-1:0] upc,
    input uop_t           uop,
    input logic [OPW-1:0] op,
    input logic           flag,
    input logic [CW-1:0]  ctrl
);
    AST_RESET_ZERO: assert property (@(posedge clk)
        rst |=> (upc == '0)); // R1

    AST_NANO_STEP: assert property (@(posedge clk) disable iff (rst)
        !uop.jump |=> (upc == $past(upc) + UAW'(1))); // R2

    AST_ALWAYS_JUMP: assert property (@(posedge clk) disable iff (rst)
        (uop.jump && uop.cond == C_ALWAYS) |=> (upc == $past(uop.tgt))); // R3

    AST_FLAG_TAKEN: assert property (@(posedge clk) disable iff (rst)
        (uop.jump && ((uop.cond == C_SET && flag) || (uop.cond == C_CLR && !flag)))
        |=> (upc == $past(uop.tgt))); // R4

    AST_FLAG_SKIP: assert property (@(posedge clk) disable iff (rst)
        (uop.jump && ((uop.cond == C_SET && !flag) || (uop.cond == C_CLR && flag)))
        |=> (upc == $past(upc) + UAW'(1))); // R4

    AST_DISPATCH: assert property (@(posedge clk) disable iff (rst)
        (uop.jump && uop.cond == C_DISP)
        |=> (upc == UAW'(DISP_BASE) + (UAW'($past(op)) << ROUT_SH))); // R5

    AST_JUMP_NOP: assert property (@(posedge clk) disable iff (rst)
        uop.jump |-> (ctrl == '0)); // R6

    for (genvar i = 0; i < N_WIDE; i++) begin : g_wide_chk
        AST_WIDE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
            !uop.jump |-> ($countones(ctrl[i*WIDE_LINES +: WIDE_LINES]) == 1)); // R7
    end

    for (genvar j = 0; j < N_NARROW; j++) begin : g_narrow_chk
        AST_NARROW_ONEHOT: assert property (@(posedge clk) disable iff (rst)
            !uop.jump |-> ($countones(ctrl[WIDE_OUT + j*NARROW_LINES +: NARROW_LINES]) == 1)); // R7
    end
endmodule

bind nano_sequencer nano_sequencer_chk u_chk (
    .clk  (clk),
    .rst  (rst),
    .upc  (upc_cur),
    .uop  (uop),
    .op   (op_code),
    .flag (cond_flag),
    .ctrl (ctrl_out)
);

// File: tb/nano_sequencer_test.sv
module nano_sequencer_test;
    logic         clk = 1'b0;
    logic         rst;
    logic [3:0]   op;
    logic         flag;
    logic [195:0] ctrl;
    int           total = 0;
    int           bad = 0;
    logic [6:0]   m_upc;

    always #5 clk = ~clk;

    nano_sequencer uut (
        .clk       (clk),
        .rst       (rst),
        .op_code   (op),
        .cond_flag (flag),
        .ctrl_out  (ctrl)
    );

    // R9: microprogram layout
    function automatic logic [16:0] exp_uword(int a);
        int k;
        if (a == 0) return 17'd1;
        if (a == 1) return 17'd2;
        if (a == 2) return {1'b1, 2'b11, 14'd0};
        if (a < 4 || a >= 68) return {1'b1, 2'b00, 14'd0};
        k = (a - 4) / 4;
        case ((a - 4) % 4)
            0: return 17'(k + 3);
            1: return {1'b1, (k % 2 == 1) ? 2'b10 : 2'b01, 14'd0};
            2: return 17'(k + 20);
            default: return {1'b1, 2'b00, 14'd0};
        endcase
    endfunction

    // R10: nanostore contents
    function automatic logic [67:0] exp_nano(int p);
        logic [67:0] w;
        for (int n = 0; n < 17; n++) w[4*n +: 4] = 4'((p + 3*n) % 16);
        return w;
    endfunction

    // R6, R7, R8: strobe vector
    function automatic logic [195:0] exp_ctrl(logic [16:0] w);
        logic [195:0] c;
        logic [67:0]  nw;
        c = '0;
        if (w[16]) return c;
        nw = exp_nano(int'(w[8:0]) % 64);
        for (int i = 0; i < 9; i++) c[16*i + int'(nw[4*i +: 4])] = 1'b1;
        for (int j = 0; j < 4; j++) c[144 + 8*j + int'(nw[36 + 3*j +: 3])] = 1'b1;
        for (int d = 0; d < 20; d++) c[176 + d] = nw[48 + d];
        return c;
    endfunction

    // R2..R5: next address
    function automatic logic [6:0] exp_next(logic [6:0] u, logic [3:0] o, logic f);
        logic [16:0] w;
        w = exp_uword(int'(u));
        if (!w[16]) return u + 7'd1;
        case (w[15:14])
            2'b00:   return w[6:0];
            2'b01:   return f ? w[6:0] : u + 7'd1;
            2'b10:   return !f ? w[6:0] : u + 7'd1;
            default: return 7'd4 + {1'b0, o, 2'b00};
        endcase
    endfunction

    task automatic check_ctrl(string tag);
        logic [195:0] e;
        e = exp_ctrl(exp_uword(int'(m_upc)));
        total++;
        if (ctrl !== e) begin
            bad++;
            $display("FAIL %s upc=%0d actual=%h expected=%h", tag, m_upc, ctrl, e);
        end
    endtask

    task automatic step(logic [3:0] o, logic f);
        logic [16:0] w;
        logic [6:0]  nxt;
        string       tag;
        w = exp_uword(int'(m_upc));
        if (!w[16])               tag = "R2";
        else if (w[15:14] == 2'b00) tag = "R3";
        else if (w[15:14] == 2'b11) tag = "R5";
        else                      tag = "R4";
        op = o;
        flag = f;
        nxt = exp_next(m_upc, o, f);
        @(posedge clk);
        m_upc = nxt;
        @(negedge clk);
        w = exp_uword(int'(m_upc));
        tag = {tag, w[16] ? " R6" : " R7 R8 R10", " R9"};
        check_ctrl(tag);
    endtask

    task automatic do_reset(string tag);
        rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        m_upc = 7'd0;
        check_ctrl({tag, " R1 held"});
        rst = 1'b0;
    endtask

    initial begin
        #1_500_000;
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_2024));
        rst = 1'b1;
        op = 4'd0;
        flag = 1'b0;
        do_reset("R1 power-up");
        // R1: first cycle after release executes address 0, then address 1
        step(4'd0, 1'b0);

        // directed: every opcode with both flag values (R4, R5)
        for (int k = 0; k < 16; k++) begin
            for (int f = 0; f < 2; f++) begin
                for (int g = 0; g < 20 && m_upc != 7'd2; g++) step(4'($urandom), 1'($urandom));
                step(4'(k), 1'(f));
                for (int g = 0; g < 8 && m_upc != 7'd0; g++) step(4'($urandom), 1'(f));
            end
        end

        // random traffic
        for (int n = 0; n < 3000; n++) begin
            step(4'($urandom), 1'($urandom));
            if (n == 1500) do_reset("R1 mid-run");
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule